// File: doc/BRIEF.md
# Asynchronous Schedule Advance Doorbell

Host software that unlinks queue heads from the circular asynchronous schedule cannot reuse their memory right away. The schedule walker may still hold a cached queue head, or that cached head's link to the next one. This block runs the handshake that tells software when reuse is safe. Software rings a doorbell bit. The block then follows the walker's queue-head fetches until no on-chip state can still point at a removed entry. At that point it raises a status bit, drops the doorbell in the same cycle, and drives an interrupt when the matching enable bit is set.

The walker reports each queue-head fetch as a valid/ready transfer that carries the address and an is-head flag. `fetch_ready` is held high at all times, so the walker is never back-pressured and every cycle with `fetch_valid` high is one accepted fetch. The `MODE` parameter chooses the completion rule. In reach mode, the block snapshots the cached queue head and its successor when the doorbell is rung, and completes once the walker has moved past both. In head-twice mode, it completes when the schedule head has been fetched twice. In either mode, disabling the schedule completes the handshake at once, because no cached state remains.

Top module: `async_adv_doorbell`

## Requirements
- R1: When `db_ring` is high while `doorbell` is 0, `doorbell` is 1 from the next cycle. On that same edge the tracker captures `cache_vld`, `cache_cur` and `cache_nxt`.
- R2: `db_ring` while `doorbell` is already 1 has no effect. The snapshot and the tracking progress are kept, and completion follows the first snapshot.
- R3: In reach mode (`MODE`=CMPL_REACH), the cached head counts as passed once an accepted fetch has an address different from `cache_cur`. The successor counts as passed once it has been fetched and a later accepted fetch has a different address. `adv_status` becomes 1 on the edge where both are passed, and not before.
- R4: In head-twice mode (`MODE`=CMPL_HEAD_TWICE), `adv_status` becomes 1 on the edge that accepts the second fetch with `fetch_head`=1 after the ring. Fetches with `fetch_head`=0 do not count.
- R5: On the edge that sets `adv_status`, `doorbell` returns to 0.
- R6: `adv_irq` equals `adv_status` AND `adv_ien` in every cycle.
- R7: `adv_status` is write-one-to-clear. `sts_wr` with `sts_wdata`=1 clears it on the next edge, and `sts_wr` with `sts_wdata`=0 leaves it unchanged. If a completion falls on the same edge as a clear, the status stays 1.
- R8: When `sched_en` is 0 while `doorbell` is 1, `adv_status` is 1 and `doorbell` is 0 on the next edge.
- R9: In reach mode, a ring with `cache_vld`=0 completes on the edge after the doorbell is set, with no fetch required.
- R10: `fetch_ready` is 1 whenever the block is out of reset.
- R11: Reset clears `doorbell`, `adv_status`, `adv_ien` and all tracking state, and `adv_irq` is 0.
- R12: `ien_wr` loads `ien_wdata` into `adv_ien` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_en | input | 1 | Asynchronous schedule enabled |
| db_ring | input | 1 | Software write of one to the doorbell |
| sts_wr | input | 1 | Software write strobe for the status bit |
| sts_wdata | input | 1 | Status write data; one clears |
| ien_wr | input | 1 | Software write strobe for the enable bit |
| ien_wdata | input | 1 | Enable write data |
| cache_vld | input | 1 | Walker currently holds a cached queue head |
| cache_cur | input | ADDR_W | Address of the cached queue head |
| cache_nxt | input | ADDR_W | Link address held by the cached queue head |
| fetch_valid | input | 1 | Walker fetch event valid |
| fetch_ready | output | 1 | Fetch event accepted (held high) |
| fetch_addr | input | ADDR_W | Address of the fetched queue head |
| fetch_head | input | 1 | Fetched queue head is the list head |
| doorbell | output | 1 | Doorbell command bit |
| adv_status | output | 1 | Advance status bit |
| adv_ien | output | 1 | Advance interrupt enable bit |
| adv_irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies side by side. One uses `MODE`=CMPL_REACH, which covers snapshot matching: revisiting the cached head, repeated rings with changed cache inputs, and an empty cache. The other uses `MODE`=CMPL_HEAD_TWICE, which covers the head-count rule with mixed head and non-head fetches. Both use the default 27-bit address width, so address compares run at full width. Shared stimulus also reaches the schedule-disable completion, the write-one-to-clear rules and a reset during a pending handshake.

// File: rtl/adv_dbl_pkg.sv
package adv_dbl_pkg;
  // Completion rule selected at build time.
  typedef enum logic {
    CMPL_REACH      = 1'b0,
    CMPL_HEAD_TWICE = 1'b1
  } cmpl_mode_e;

  // Snapshot slots: slot 0 is the cached queue head, slot 1 its successor.
  localparam int unsigned SNAP_SLOTS = 2;
endpackage

// File: rtl/adv_dbl_regs.sv
module adv_dbl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_req,
  input  logic sts_wr,
  input  logic sts_wdata,
  input  logic ien_wr,
  input  logic ien_wdata,
  input  logic trk_done,
  output logic start,
  output logic db_q,
  output logic sts_q,
  output logic ien_q,
  output logic irq
);
  // A ring only starts a handshake when none is pending.
  assign start = ring_req & ~db_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q  <= 1'b0;
      sts_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (trk_done)   db_q <= 1'b0;
      else if (start) db_q <= 1'b1;

      // Completion wins over a software clear on the same edge.
      if (trk_done)                 sts_q <= 1'b1;
      else if (sts_wr && sts_wdata) sts_q <= 1'b0;

      if (ien_wr) ien_q <= ien_wdata;
    end
  end

  assign irq = sts_q & ien_q;
endmodule

// File: rtl/adv_dbl_reach.sv
module adv_dbl_reach #(
  parameter int unsigned ADDR_W = 27,
  parameter int unsigned SLOTS  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         sched_en,
  input  logic                         cache_vld,
  input  logic [SLOTS-1:0][ADDR_W-1:0] snap_in,
  input  logic                         fire,
  input  logic [ADDR_W-1:0]            fetch_addr,
  output logic                         active,
  output logic                         done
);
  logic             active_q;
  logic [SLOTS-1:0] pass_now;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // Slot 0 is already resident in the walker, so it starts as visited.
    localparam logic VISITED_INIT = (s == 0);
    logic              live_q;
    logic              seen_q;
    logic              gone_q;
    logic [ADDR_W-1:0] addr_q;
    logic              lands;
    logic              moved_off;

    assign lands     = fire & (fetch_addr == addr_q);
    assign moved_off = fire & ~lands & seen_q;
    assign pass_now[s] = ~live_q | gone_q | moved_off;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q <= 1'b0;
        seen_q <= 1'b0;
        gone_q <= 1'b0;
        addr_q <= '0;
      end else if (start) begin
        live_q <= cache_vld;
        seen_q <= VISITED_INIT;
        gone_q <= 1'b0;
        addr_q <= snap_in[s];
      end else if (active_q) begin
        if (lands)     seen_q <= 1'b1;
        if (moved_off) gone_q <= 1'b1;
      end
    end
  end

  assign done   = active_q & ((&pass_now) | ~sched_en);
  assign active = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     active_q <= 1'b0;
    else if (done)  active_q <= 1'b0;
    else if (start) active_q <= 1'b1;
  end
endmodule

// File: rtl/adv_dbl_headcnt.sv
module adv_dbl_headcnt #(
  parameter int unsigned HEAD_PASSES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sched_en,
  input  logic fire,
  input  logic is_head,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(HEAD_PASSES + 1);
  localparam logic [CW-1:0] LAST = CW'(HEAD_PASSES - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  logic          head_hit;

  assign head_hit = fire & is_head;
  assign done     = active_q & ((head_hit & (cnt_q == LAST)) | ~sched_en);
  assign active   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (done)          active_q <= 1'b0;
      else if (head_hit) cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/async_adv_doorbell.sv
module async_adv_doorbell
  import adv_dbl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 27,
  parameter cmpl_mode_e  MODE        = CMPL_REACH,
  parameter int unsigned HEAD_PASSES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sched_en,
  input  logic              db_ring,
  input  logic              sts_wr,
  input  logic              sts_wdata,
  input  logic              ien_wr,
  input  logic              ien_wdata,
  input  logic              cache_vld,
  input  logic [ADDR_W-1:0] cache_cur,
  input  logic [ADDR_W-1:0] cache_nxt,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_head,
  output logic              doorbell,
  output logic              adv_status,
  output logic              adv_ien,
  output logic              adv_irq
);
  logic trk_start;
  logic trk_done;
  logic trk_active;
  logic fire;

  // Fetch events are never stalled.
  assign fetch_ready = 1'b1;
  assign fire        = fetch_valid & fetch_ready;

  adv_dbl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_req  (db_ring),
    .sts_wr    (sts_wr),
    .sts_wdata (sts_wdata),
    .ien_wr    (ien_wr),
    .ien_wdata (ien_wdata),
    .trk_done  (trk_done),
    .start     (trk_start),
    .db_q      (doorbell),
    .sts_q     (adv_status),
    .ien_q     (adv_ien),
    .irq       (adv_irq)
  );

  if (MODE == CMPL_REACH) begin : g_reach
    logic [SNAP_SLOTS-1:0][ADDR_W-1:0] snap_in;
    logic unused_head;
    assign snap_in[0]  = cache_cur;
    assign snap_in[1]  = cache_nxt;
    assign unused_head = fetch_head;

    adv_dbl_reach #(.ADDR_W(ADDR_W), .SLOTS(SNAP_SLOTS)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (trk_start),
      .sched_en   (sched_en),
      .cache_vld  (cache_vld),
      .snap_in    (snap_in),
      .fire       (fire),
      .fetch_addr (fetch_addr),
      .active     (trk_active),
      .done       (trk_done)
    );
  end else begin : g_head
    logic unused_cache;
    assign unused_cache = ^{cache_vld, cache_cur, cache_nxt, fetch_addr};

    adv_dbl_headcnt #(.HEAD_PASSES(HEAD_PASSES)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (trk_start),
      .sched_en (sched_en),
      .fire     (fire),
      .is_head  (fetch_head),
      .active   (trk_active),
      .done     (trk_done)
    );
  end
endmodule

// File: rtl/adv_dbl_chk.sv
module adv_dbl_chk (
  input logic clk,
  input logic rst_n,
  input logic db_ring,
  input logic sts_wr,
  input logic sts_wdata,
  input logic sched_en,
  input logic doorbell,
  input logic adv_status,
  input logic adv_ien,
  input logic adv_irq,
  input logic trk_active
);
  assert_ring_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    db_ring && !doorbell |=> doorbell);

  assert_tracker_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell == trk_active);

  assert_set_clears_db_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv_status) |-> !doorbell && $past(doorbell));

  assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    adv_irq == (adv_status && adv_ien));

  assert_zero_write_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_status && sts_wr && !sts_wdata |=> adv_status);

  assert_one_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr && sts_wdata && !doorbell |=> !adv_status);

  assert_sched_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell && !sched_en |=> adv_status && !doorbell);

  assert_reset_clears_R11: assert property (@(posedge clk)
    !rst_n |=> !doorbell && !adv_status && !adv_ien);
endmodule

bind async_adv_doorbell adv_dbl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .db_ring    (db_ring),
  .sts_wr     (sts_wr),
  .sts_wdata  (sts_wdata),
  .sched_en   (sched_en),
  .doorbell   (doorbell),
  .adv_status (adv_status),
  .adv_ien    (adv_ien),
  .adv_irq    (adv_irq),
  .trk_active (trk_active)
);

// File: tb/async_adv_doorbell_tb_top.sv
module async_adv_doorbell_tb_top;
  localparam int AW = 27;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sched_en, db_ring, sts_wr, sts_wdata, ien_wr, ien_wdata;
  logic cache_vld, fetch_valid, fetch_head;
  logic [AW-1:0] cache_cur, cache_nxt, fetch_addr;
  logic r_rdy, r_db, r_sts, r_ien, r_irq;
  logic h_rdy, h_db, h_sts, h_ien, h_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];
  int mon_e;
  bit mon_en = 1'b1;
  bit finished = 1'b0;
  logic sts_prev = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  async_adv_doorbell #(.ADDR_W(AW), .MODE(adv_dbl_pkg::CMPL_REACH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .db_ring(db_ring),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .cache_vld(cache_vld), .cache_cur(cache_cur), .cache_nxt(cache_nxt),
    .fetch_valid(fetch_valid), .fetch_ready(r_rdy), .fetch_addr(fetch_addr),
    .fetch_head(fetch_head), .doorbell(r_db), .adv_status(r_sts),
    .adv_ien(r_ien), .adv_irq(r_irq)
  );

  async_adv_doorbell #(.ADDR_W(AW), .MODE(adv_dbl_pkg::CMPL_HEAD_TWICE)) dut_h_i (
    .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .db_ring(db_ring),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .cache_vld(cache_vld), .cache_cur(cache_cur), .cache_nxt(cache_nxt),
    .fetch_valid(fetch_valid), .fetch_ready(h_rdy), .fetch_addr(fetch_addr),
    .fetch_head(fetch_head), .doorbell(h_db), .adv_status(h_sts),
    .adv_ien(h_ien), .adv_irq(h_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ring();
    db_ring = 1'b1;
    step();
    db_ring = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input logic h);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    fetch_head  = h;
    step();
    fetch_valid = 1'b0;
    fetch_head  = 1'b0;
  endtask

  task automatic clear_sts(input logic v);
    sts_wr    = 1'b1;
    sts_wdata = v;
    step();
    sts_wr    = 1'b0;
    sts_wdata = 1'b0;
  endtask

  // Scoreboard monitor: every rise of the reach-mode status bit must match
  // the oldest predicted completion cycle.
  always @(negedge clk) begin
    if (rst_n && mon_en && r_sts && !sts_prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3: completion at cycle %0d, expected none", cyc);
      end else begin
        mon_e = exp_q.pop_front();
        if (mon_e != cyc) begin
          fails++;
          $display("FAIL R3: completion at cycle %0d, expected cycle %0d", cyc, mon_e);
        end
      end
    end
    sts_prev = r_sts;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sched_en = 1'b1; db_ring = 1'b0; sts_wr = 1'b0; sts_wdata = 1'b0;
    ien_wr = 1'b0; ien_wdata = 1'b0; cache_vld = 1'b1; fetch_valid = 1'b0;
    fetch_head = 1'b0; cache_cur = '0; cache_nxt = '0; fetch_addr = '0;
    repeat (3) step();
    chk("R11 reset doorbell", r_db, 0);
    chk("R11 reset status", r_sts, 0);
    chk("R11 reset irq", r_irq, 0);
    rst_n = 1'b1;
    step();
    chk("R10 ready", r_rdy, 1);

    // R3: reach rule, revisit of the cached head does not pass it
    cache_cur = 27'h100; cache_nxt = 27'h200;
    ring();
    chk("R1 doorbell set", r_db, 1);
    fetch(27'h100, 1'b0);
    chk("R3 no early set after cached refetch", r_sts, 0);
    fetch(27'h200, 1'b0);
    chk("R3 no early set on successor", r_sts, 0);
    exp_q.push_back(cyc + 1);
    fetch(27'h300, 1'b0);
    chk("R3 status after passing both", r_sts, 1);
    chk("R5 doorbell cleared", r_db, 0);
    chk("R6 irq low without enable", r_irq, 0);

    ien_wr = 1'b1; ien_wdata = 1'b1; step(); ien_wr = 1'b0;
    chk("R12 enable loaded", r_ien, 1);
    chk("R6 irq raised", r_irq, 1);
    clear_sts(1'b0);
    chk("R7 zero write keeps status", r_sts, 1);
    clear_sts(1'b1);
    chk("R7 one write clears status", r_sts, 0);
    chk("R6 irq drops", r_irq, 0);

    // R2: second ring with new cache contents is ignored
    cache_cur = 27'h400; cache_nxt = 27'h500;
    ring();
    cache_cur = 27'h600; cache_nxt = 27'h700;
    ring();
    chk("R2 doorbell still pending", r_db, 1);
    fetch(27'h500, 1'b0);
    chk("R2 no set on first snapshot successor", r_sts, 0);
    exp_q.push_back(cyc + 1);
    fetch(27'h800, 1'b0);
    chk("R2 completion follows first snapshot", r_sts, 1);
    clear_sts(1'b1);

    // R8: schedule disabled while pending
    ring();
    sched_en = 1'b0;
    exp_q.push_back(cyc + 1);
    step();
    chk("R8 status on disable", r_sts, 1);
    chk("R8 doorbell cleared", r_db, 0);
    sched_en = 1'b1;
    clear_sts(1'b1);

    // R9: nothing cached at ring
    cache_vld = 1'b0;
    exp_q.push_back(cyc + 2);
    ring();
    chk("R9 doorbell set", r_db, 1);
    chk("R9 not yet complete", r_sts, 0);
    step();
    chk("R9 completes next edge", r_sts, 1);

    // R7: completion wins over a same-edge clear
    ring();
    sts_wr = 1'b1; sts_wdata = 1'b1;
    step();
    sts_wr = 1'b0; sts_wdata = 1'b0;
    chk("R7 completion beats clear", r_sts, 1);
    chk("R5 doorbell cleared on completion", r_db, 0);
    cache_vld = 1'b1;
    chk("R3 no missed completions", exp_q.size(), 0);

    // R4: head-twice variant
    mon_en = 1'b0;
    rst_n = 1'b0; step(); step(); rst_n = 1'b1; step();
    ring();
    chk("R4 head doorbell set", h_db, 1);
    fetch(27'h100, 1'b1);
    chk("R4 one head is not enough", h_sts, 0);
    fetch(27'h200, 1'b0);
    fetch(27'h300, 1'b0);
    chk("R4 non-head fetches do not count", h_sts, 0);
    fetch(27'h100, 1'b1);
    chk("R4 status on second head", h_sts, 1);
    chk("R5 head doorbell cleared", h_db, 0);

    // R11: reset during a pending handshake
    ien_wr = 1'b1; ien_wdata = 1'b1; step(); ien_wr = 1'b0;
    ring();
    chk("R11 pending before reset", r_db, 1);
    rst_n = 1'b0;
    step();
    chk("R11 doorbell cleared", r_db, 0);
    chk("R11 status cleared", r_sts | h_sts, 0);
    chk("R11 enable cleared", r_ien | h_ien, 0);
    chk("R11 irq low", r_irq | h_irq, 0);
    rst_n = 1'b1;
    step();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule